// File: doc/BRIEF.md
# Non-Recursive Three-Section Sinc Decimator

This block is the first rate-reduction stage behind a single-bit sigma-delta modulator for audio. The modulator is sampled at 1.6 MHz and has a 25 kHz signal band. The whole decimation chain has an oversampling ratio of 32. This block takes 8x of that. A half-band filter and a final FIR filter, both outside this block, take the remaining 4x.

The block chains three identical sections. Each section applies a fourth-order sinc window, (1+z^-1)^4, and keeps every second result. No section holds an integrator that runs at the input rate, so nothing depends on wrap-around arithmetic.

Each section keeps a short history of its past inputs. It evaluates the weighted sum only on the sample that completes a pair, so its adders and output register switch at that section's output rate. History registers load only when a sample arrives.

The input is a one-bit stream with a valid/ready handshake. The output is a signed word with its own valid/ready handshake. Back-pressure works as follows:
- While a result is waiting at the output and `out_ready` is low, the whole chain freezes and `in_ready` is low.
- In that state no new bit is taken.
- Samples that arrive with `in_valid` low are not samples: they advance nothing.

Top module: `sinc_decim8`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `out_valid` is 0 and `in_ready` is 1. All history registers, pair-phase counters and warm-up counters are cleared.
- R2: An input bit of 1 is taken as +1, and an input bit of 0 is taken as -1. A long run of ones settles at +4096 on the output. A long run of zeros settles at -4096.
- R3: Each section numbers its accepted samples from 0 after reset. Its result j is x[2j+5] + 4·x[2j+4] + 6·x[2j+3] + 4·x[2j+2] + x[2j+1]. The three sections are cascaded, and the output word sequence equals section 3's results in order.
- R4: A section gives no result until its window is full. The first word reaches the output only after the 36th accepted input bit, and no word appears after 35. In steady state, exactly one word is produced per 8 accepted bits.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold their values and `in_ready` is 0.
- R6: `out_data` is 14-bit two's complement and always lies within -4096..+4096.
- R7: A reset in the middle of a stream discards all history. The following output matches a fresh start.
- R8: Clock cycles with `in_valid` low leave the result sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input bit is present |
| in_ready | output | 1 | Block accepts a bit this cycle |
| in_bit | input | 1 | Modulator bit (1 is +1, 0 is -1) |
| out_valid | output | 1 | Output word is present |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 14 | Decimated sample, signed |

## Verification
The bench uses several input patterns, each aimed at a different fault:
- Runs of all ones and all zeros pin down the bit mapping and the full-scale gain of the cascade.
- A step from zeros to ones exercises every binomial weight of each window as the edge passes through.
- Random bitstreams with random input gaps and random output stalls separate correct pair phasing and stall freezing from lost or repeated samples.
- An exact count of 35, then 36, then 44 accepted bits fixes the warm-up length and the 8:1 rate.
- A reset in the middle of a stream, followed by ones, shows whether stale history leaks into later results.

// File: rtl/sinc_decim_pkg.sv
package sinc_decim_pkg;

  // Binomial coefficient n choose k, used as window weight
  function automatic int binom(input int n, input int k);
    int r;
    r = 1;
    for (int i = 0; i < k; i++) r = (r * (n - i)) / (i + 1);
    return r;
  endfunction

  // Bit offset of data segment g in the flattened inter-section bus
  function automatic int seg_off(input int g, input int in_w, input int order);
    return g * in_w + (order * g * (g - 1)) / 2;
  endfunction

endpackage

// File: rtl/sinc_half_section.sv
module sinc_half_section #(
  parameter int IN_W   = 2,
  parameter int ORDER  = 4,
  parameter int WARM   = 2,
  parameter int IN_MAG = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       adv,
  input  logic                       v_i,
  input  logic signed [IN_W-1:0]     d_i,
  output logic                       v_o,
  output logic signed [IN_W+ORDER-1:0] d_o
);
  localparam int SO     = IN_W + ORDER;
  localparam int TAPS   = ORDER + 1;
  localparam int WCW    = $clog2(WARM + 2);
  localparam int FULL   = 2 * (WARM + 1);
  localparam int SEEN_W = $clog2(FULL + 2) + 1;
  localparam int LIM    = IN_MAG * (2 ** ORDER);

  logic signed [IN_W-1:0] hist [ORDER];
  logic                   phase;
  logic [WCW-1:0]         warm_cnt;
  logic signed [SO-1:0]   ext  [TAPS];
  logic signed [SO-1:0]   prod [TAPS];
  logic signed [SO-1:0]   acc;
  logic                   take, emit, warm_done;

  assign take      = adv && v_i;
  assign emit      = take && phase;
  assign warm_done = (warm_cnt == WCW'(WARM));

  // Weighted window: newest sample at tap 0
  assign ext[0] = SO'(d_i);
  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    localparam logic signed [SO-1:0] CK = SO'(sinc_decim_pkg::binom(ORDER, g));
    if (g > 0) begin : g_hist
      assign ext[g] = SO'(hist[g-1]);
    end
    assign prod[g] = CK * ext[g];
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < TAPS; k++) acc = acc + prod[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ORDER; i++) hist[i] <= '0;
      phase    <= 1'b0;
      warm_cnt <= '0;
      v_o      <= 1'b0;
      d_o      <= '0;
    end else if (adv) begin
      v_o <= emit && warm_done;
      if (take) begin
        hist[0] <= d_i;
        for (int i = 1; i < ORDER; i++) hist[i] <= hist[i-1];
        phase <= ~phase;
      end
      if (emit) begin
        d_o <= acc;
        if (!warm_done) warm_cnt <= warm_cnt + 1'b1;
      end
    end
  end

  // Checker-side count of accepted samples, saturating
  logic [SEEN_W-1:0] seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (take && seen < SEEN_W'(FULL)) seen <= seen + 1'b1;
  end

  assert_pair_phase_R3: assert property (@(posedge clk) disable iff (rst)
    v_o |-> !phase);
  assert_warmup_R4: assert property (@(posedge clk) disable iff (rst)
    v_o |-> (seen >= SEEN_W'(FULL)));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    v_o |-> (int'(d_o) <= LIM && int'(d_o) >= -LIM));

endmodule

// File: rtl/sinc_decim8.sv
module sinc_decim8 #(
  parameter int STAGES = 3,
  parameter int ORDER  = 4,
  parameter int WARM   = 2,
  localparam int OUT_W = 2 + STAGES * ORDER
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  localparam int IN_W = 2;
  localparam int TOT  = sinc_decim_pkg::seg_off(STAGES + 1, IN_W, ORDER);

  logic [TOT-1:0]  flat;
  logic [STAGES:0] vld;
  logic            adv;

  // The whole chain advances unless a finished word is stalled
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  assign vld[0] = in_valid;
  assign flat[sinc_decim_pkg::seg_off(0, IN_W, ORDER) +: IN_W] =
    in_bit ? 2'sb01 : 2'sb11;

  for (genvar g = 0; g < STAGES; g++) begin : g_sec
    localparam int WI  = IN_W + g * ORDER;
    localparam int OI  = sinc_decim_pkg::seg_off(g, IN_W, ORDER);
    localparam int OO  = sinc_decim_pkg::seg_off(g + 1, IN_W, ORDER);
    localparam int MAG = 1 << (g * ORDER);
    logic signed [WI+ORDER-1:0] y;
    sinc_half_section #(
      .IN_W(WI), .ORDER(ORDER), .WARM(WARM), .IN_MAG(MAG)
    ) sec_i (
      .clk(clk), .rst(rst), .adv(adv),
      .v_i(vld[g]), .d_i(flat[OI +: WI]),
      .v_o(vld[g+1]), .d_o(y)
    );
    assign flat[OO +: WI+ORDER] = y;
  end

  assign out_valid = vld[STAGES];
  assign out_data  = flat[sinc_decim_pkg::seg_off(STAGES, IN_W, ORDER) +: OUT_W];

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/sinc_decim8_tb.sv
`timescale 1ns/1ps
module sinc_decim8_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [13:0] out_data;

  always #2.5 clk = ~clk;

  sinc_decim8 dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  int n_checks = 0, n_fail = 0;
  int x0[$], s1[$], s2[$], expq[$];
  int out_count = 0, last_out = 0;
  bit prev_stall = 0;
  logic [13:0] prev_data;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int win(input int a, input int b, input int c, input int d, input int e);
    return a + 4*b + 6*c + 4*d + e;
  endfunction

  // Behavioural model: each list keeps every value; a result every even size from 6
  task automatic model_in(input int v);
    int n;
    x0.push_back(v);
    n = x0.size();
    if (n >= 6 && n % 2 == 0) begin
      s1.push_back(win(x0[n-1], x0[n-2], x0[n-3], x0[n-4], x0[n-5]));
      n = s1.size();
      if (n >= 6 && n % 2 == 0) begin
        s2.push_back(win(s1[n-1], s1[n-2], s1[n-3], s1[n-4], s1[n-5]));
        n = s2.size();
        if (n >= 6 && n % 2 == 0)
          expq.push_back(win(s2[n-1], s2[n-2], s2[n-3], s2[n-4], s2[n-5]));
      end
    end
  endtask

  // Monitor: samples just after the falling edge, predicts the next rising edge
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (prev_stall)
        chk(out_valid === 1'b1 && out_data === prev_data, "R5 hold",
            int'($signed(out_data)), int'($signed(prev_data)));
      if (out_valid && !out_ready)
        chk(in_ready === 1'b0, "R5 in_ready low", int'(in_ready), 0);
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (in_valid && in_ready) model_in(in_bit ? 1 : -1);
      if (out_valid && out_ready) begin
        out_count++;
        last_out = int'($signed(out_data));
        if (expq.size() == 0)
          chk(1'b0, "R3 unexpected word", last_out, 0);
        else begin
          int e;
          e = expq.pop_front();
          chk(last_out == e, "R3 word value", last_out, e);
        end
        chk(last_out <= 4096 && last_out >= -4096, "R6 range", last_out, 4096);
      end
    end else begin
      prev_stall = 0;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    x0.delete(); s1.delete(); s2.delete(); expq.delete();
    out_count = 0;
    #1;
    chk(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready === 1'b1, "R1 in_ready", int'(in_ready), 1);
  endtask

  // Present one bit until it is accepted
  task automatic send(input bit b, input bit gappy, input bit stally);
    bit acc;
    acc = 0;
    while (!acc) begin
      @(negedge clk);
      in_valid  = gappy ? 1'($urandom_range(0, 1)) : 1'b1;
      in_bit    = b;
      out_ready = stally ? 1'($urandom_range(0, 1)) : 1'b1;
      #0.5;
      acc = in_valid && in_ready;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1;
    end
  endtask

  task automatic drain();
    idle(10);
    chk(expq.size() == 0, "R3 all words delivered", expq.size(), 0);
  endtask

  initial begin
    do_reset();
    // R4: warm-up length and rate
    for (int i = 0; i < 35; i++) send(1'b1, 0, 0);
    idle(8);
    chk(out_count == 0, "R4 no word after 35", out_count, 0);
    send(1'b1, 0, 0);
    idle(6);
    chk(out_count == 1, "R4 word after 36", out_count, 1);
    for (int i = 0; i < 7; i++) send(1'b1, 0, 0);
    idle(6);
    chk(out_count == 1, "R4 none after 43", out_count, 1);
    send(1'b1, 0, 0);
    idle(6);
    chk(out_count == 2, "R4 second after 44", out_count, 2);
    // R2: full-scale ones
    for (int i = 0; i < 40; i++) send(1'b1, 0, 0);
    drain();
    chk(last_out == 4096, "R2 ones settle", last_out, 4096);

    // R2: full-scale zeros
    do_reset();
    for (int i = 0; i < 80; i++) send(1'b0, 0, 0);
    drain();
    chk(last_out == -4096, "R2 zeros settle", last_out, -4096);

    // R3: step from zeros to ones
    do_reset();
    for (int i = 0; i < 60; i++) send(1'b0, 0, 0);
    for (int i = 0; i < 100; i++) send(1'b1, 0, 0);
    drain();
    chk(last_out == 4096, "R3 step end", last_out, 4096);

    // R3/R5/R8: random bits, gaps, stalls
    do_reset();
    for (int i = 0; i < 3000; i++) send(1'($urandom_range(0, 1)), 1, 1);
    drain();

    // R8: gaps only, ones
    do_reset();
    for (int i = 0; i < 100; i++) send(1'b1, 1, 0);
    drain();
    chk(out_count == 9, "R8 gap count", out_count, 9);

    // R7: reset mid-stream then ones
    do_reset();
    for (int i = 0; i < 50; i++) send(1'b0, 0, 0);
    do_reset();
    for (int i = 0; i < 36; i++) send(1'b1, 0, 0);
    idle(6);
    chk(out_count == 1 && last_out == 4096, "R7 fresh after reset", last_out, 4096);
    drain();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule